// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sits between an address generation stage and the translation lookaside buffer. For every request it resolves the effective privilege level from the status bits and classifies the 64-bit virtual address into one of three routes: a lookup through the translation buffer, a direct (unmapped) translation with a cacheability attribute, or an address error tagged as a load or store fault. The translation buffer itself and the exception vectoring that consumes the fault are handled elsewhere.

The block is purely combinational. The route is qualified by a request-valid input, and all outputs are held at zero while no request is presented. The effective 64-bit addressing enable for the resolved privilege is also brought out, so that a fault handler can record the width of the faulting access.

Top module: `va_segment_decoder`

## Requirements
- R1: The effective privilege is kernel when `exl` or `erl` is 1, whatever `mode_field` holds. Otherwise `mode_field` 2'b00 is kernel, 2'b01 is supervisor, and 2'b10 or the reserved 2'b11 is user.
- R2: With a valid request, `ext_addr` equals `kx_en` for kernel, `sx_en` for supervisor and `ux_en` for user.
- R3: With `req_valid` at 1, exactly one of `is_lookup`, `is_direct` and `is_fault` is 1.
- R4: With `req_valid` at 0, every output is 0.
- R5: In any privilege, an address whose bits [63:62] are 2'b10 is direct, with `phys_addr` equal to `vaddr[43:0]` and `phys_cached` at 1.
- R6: An address from 0 to 0x7FFFFFFF with `erl` at 0 is sent to lookup, in any privilege.
- R7: An address from 0 to 0x7FFFFFFF with `erl` at 1 is direct and uncached, with `phys_addr` equal to the address.
- R8: An address with bits [63:32] all zero and bit 31 set is classified as if bits [63:32] were all ones.
- R9: In kernel privilege, an address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF (after R8) is direct, with `phys_addr` equal to its low 29 bits; `phys_cached` is 1 below 0xFFFFFFFFA0000000 and 0 from there up.
- R10: In kernel privilege, any address above 0x7FFFFFFF not covered by R5 or R9 is sent to lookup; kernel privilege never faults.
- R11: In supervisor or user privilege, an address above 0x7FFFFFFF not covered by R5 faults. `fault_code` is 2'b10 for a store (`is_store` 1), 2'b01 for a load, and 2'b00 whenever `is_fault` is 0.
- R12: When `is_direct` is 0, `phys_addr` and `phys_cached` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | A request is presented this cycle |
| vaddr | input | 64 | Virtual address to classify |
| is_store | input | 1 | 1 for a store, 0 for a load |
| mode_field | input | 2 | Privilege field from the status word |
| exl | input | 1 | Exception-level flag |
| erl | input | 1 | Error-level flag |
| ux_en | input | 1 | 64-bit addressing enable for user |
| sx_en | input | 1 | 64-bit addressing enable for supervisor |
| kx_en | input | 1 | 64-bit addressing enable for kernel |
| is_lookup | output | 1 | Address goes through the translation buffer |
| is_direct | output | 1 | Address is translated directly |
| is_fault | output | 1 | Address error |
| phys_addr | output | 44 | Physical address of a direct translation |
| phys_cached | output | 1 | Direct translation is cacheable |
| fault_code | output | 2 | 2'b01 load error, 2'b10 store error, 2'b00 none |
| ext_addr | output | 1 | 64-bit addressing enabled for the effective privilege |

## Verification
The assertions watch, on every evaluation, that a valid request gets exactly one route, that an idle request drives nothing, that the high direct-physical window and the low mapped segment are routed correctly, that kernel privilege never faults, and that the fault code and the direct-only outputs stay consistent with the route. Only the bench's sweeps can show the exact physical address and cache split of the two kernel windows, the sign extension of 32-bit addresses, the override of the privilege field by the exception and error flags, the treatment of the reserved field value and the per-privilege choice of the 64-bit enable.

// File: rtl/vsd_pkg.sv
`timescale 1ns/1ps
// Shared types for the virtual address segment decoder.
// Assumes a two-bit privilege field and a two-bit fault code at the ports.
package vsd_pkg;

    // Resolved privilege level.
    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_USER   = 2'b10
    } priv_e;

    // Fault code carried with an address error.
    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_LOAD  = 2'b01,
        FLT_STORE = 2'b10
    } flt_e;

    // Route chosen for one address.
    typedef enum logic [1:0] {
        ROUTE_TLB    = 2'b00,
        ROUTE_DIRECT = 2'b01,
        ROUTE_FAULT  = 2'b10
    } route_e;

endpackage

// File: rtl/vsd_priv_resolve.sv
`timescale 1ns/1ps
// Resolves the effective privilege from the status bits and picks the
// 64-bit addressing enable that belongs to it.
// Assumes: exception or error level forces kernel; the reserved field
// value 2'b11 behaves as user.
module vsd_priv_resolve
    import vsd_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic       exl,
    input  logic       erl,
    input  logic       ux_en,
    input  logic       sx_en,
    input  logic       kx_en,
    output priv_e      priv,
    output logic       ext_addr
);

    // Privilege resolution with the exception/error override.
    always_comb begin
        if (exl || erl) begin
            priv = PRIV_KERNEL;
        end else begin
            case (mode_field)
                2'b00:   priv = PRIV_KERNEL;
                2'b01:   priv = PRIV_SUPER;
                default: priv = PRIV_USER;
            endcase
        end
    end

    // Select the 64-bit enable of the resolved privilege.
    always_comb begin
        case (priv)
            PRIV_KERNEL: ext_addr = kx_en;
            PRIV_SUPER:  ext_addr = sx_en;
            default:     ext_addr = ux_en;
        endcase
    end

endmodule

// File: rtl/vsd_addr_norm.sv
`timescale 1ns/1ps
// Normalises the virtual address and flags the two regions that are
// decided without regard to privilege.
// Assumes: a 32-bit address (upper word zero, bit SEXT_BIT set) is
// sign-extended; the direct-physical window is top bits 2'b10.
module vsd_addr_norm #(
    parameter int VA_W     = 64,
    parameter int SEXT_BIT = 31
) (
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] norm_va,
    output logic            in_low,
    output logic            in_phys
);

    localparam int HI_W = VA_W - SEXT_BIT - 1;

    generate
        if (HI_W > 0) begin : g_sext
            logic upper_zero;
            // Detect a 32-bit address in the upper half of its range.
            always_comb upper_zero = (vaddr[VA_W-1:SEXT_BIT+1] == '0);
            // Sign-extend such an address to the full width.
            always_comb begin
                if (upper_zero && vaddr[SEXT_BIT])
                    norm_va = {{HI_W{1'b1}}, vaddr[SEXT_BIT:0]};
                else
                    norm_va = vaddr;
            end
        end else begin : g_pass
            // Address is no wider than the extension point: pass through.
            always_comb norm_va = vaddr;
        end
    endgenerate

    // Low mapped segment: everything above the extension bit is zero.
    always_comb in_low = (vaddr[VA_W-1:SEXT_BIT] == '0);

    // Direct-physical window on the top two bits.
    always_comb in_phys = (vaddr[VA_W-1:VA_W-2] == 2'b10);

endmodule

// File: rtl/vsd_region_sel.sv
`timescale 1ns/1ps
// Chooses the route, the direct physical address, the cacheability and
// the fault code for one normalised address.
// Assumes: priority is physical window, then low segment, then the
// privilege-dependent decode of the remaining space.
module vsd_region_sel
    import vsd_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 44,
    parameter int WIN_W = 29
) (
    input  priv_e           priv,
    input  logic            erl,
    input  logic            is_store,
    input  logic [VA_W-1:0] norm_va,
    input  logic            in_low,
    input  logic            in_phys,
    output route_e          route,
    output logic [PA_W-1:0] phys,
    output logic            cached,
    output flt_e            fcode
);

    // Bit that splits the kernel windows from the mapped kernel space,
    // and the width of the low segment.
    localparam int SPLIT_BIT = WIN_W + 1;
    localparam int LOW_W     = WIN_W + 2;

    logic in_kwin;

    // Two adjacent kernel windows: all ones above LOW_W, split bit clear.
    always_comb in_kwin = (&norm_va[VA_W-1:LOW_W]) && !norm_va[SPLIT_BIT];

    // Prioritised route decision.
    always_comb begin
        route  = ROUTE_TLB;
        phys   = '0;
        cached = 1'b0;
        fcode  = FLT_NONE;
        if (in_phys) begin
            route  = ROUTE_DIRECT;
            phys   = norm_va[PA_W-1:0];
            cached = 1'b1;
        end else if (in_low) begin
            if (erl) begin
                route = ROUTE_DIRECT;
                phys  = PA_W'(norm_va[LOW_W-1:0]);
            end
        end else if (priv == PRIV_KERNEL) begin
            if (in_kwin) begin
                route  = ROUTE_DIRECT;
                phys   = PA_W'(norm_va[WIN_W-1:0]);
                cached = !norm_va[WIN_W];
            end
        end else begin
            route = ROUTE_FAULT;
            fcode = is_store ? FLT_STORE : FLT_LOAD;
        end
    end

endmodule

// File: rtl/va_segment_decoder.sv
`timescale 1ns/1ps
// Virtual address segment decoder top level.
// Classifies each valid request as lookup, direct or fault, and drives
// all outputs to zero while no request is presented.
// Assumes: purely combinational; PA_W is at least WIN_W + 2.
module va_segment_decoder
    import vsd_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int PA_W  = 44,
    parameter int WIN_W = 29
) (
    input  logic            req_valid,
    input  logic [VA_W-1:0] vaddr,
    input  logic            is_store,
    input  logic [1:0]      mode_field,
    input  logic            exl,
    input  logic            erl,
    input  logic            ux_en,
    input  logic            sx_en,
    input  logic            kx_en,
    output logic            is_lookup,
    output logic            is_direct,
    output logic            is_fault,
    output logic [PA_W-1:0] phys_addr,
    output logic            phys_cached,
    output logic [1:0]      fault_code,
    output logic            ext_addr
);

    localparam int SEXT_BIT = WIN_W + 2;

    priv_e           priv;
    logic            ext_raw;
    logic [VA_W-1:0] norm_va;
    logic            in_low;
    logic            in_phys;
    route_e          route;
    logic [PA_W-1:0] phys;
    logic            cached;
    flt_e            fcode;

    vsd_priv_resolve u_priv (
        .mode_field (mode_field),
        .exl        (exl),
        .erl        (erl),
        .ux_en      (ux_en),
        .sx_en      (sx_en),
        .kx_en      (kx_en),
        .priv       (priv),
        .ext_addr   (ext_raw)
    );

    vsd_addr_norm #(
        .VA_W     (VA_W),
        .SEXT_BIT (SEXT_BIT)
    ) u_norm (
        .vaddr   (vaddr),
        .norm_va (norm_va),
        .in_low  (in_low),
        .in_phys (in_phys)
    );

    vsd_region_sel #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .WIN_W (WIN_W)
    ) u_sel (
        .priv     (priv),
        .erl      (erl),
        .is_store (is_store),
        .norm_va  (norm_va),
        .in_low   (in_low),
        .in_phys  (in_phys),
        .route    (route),
        .phys     (phys),
        .cached   (cached),
        .fcode    (fcode)
    );

    // Qualify every output with the request-valid input.
    always_comb begin
        is_lookup   = 1'b0;
        is_direct   = 1'b0;
        is_fault    = 1'b0;
        phys_addr   = '0;
        phys_cached = 1'b0;
        fault_code  = FLT_NONE;
        ext_addr    = 1'b0;
        if (req_valid) begin
            is_lookup   = (route == ROUTE_TLB);
            is_direct   = (route == ROUTE_DIRECT);
            is_fault    = (route == ROUTE_FAULT);
            phys_addr   = phys;
            phys_cached = cached;
            fault_code  = fcode;
            ext_addr    = ext_raw;
        end
    end

endmodule

// File: rtl/vsd_checker.sv
`timescale 1ns/1ps
// Property checker for the segment decoder, attached by bind.
// Uses immediate assertions because the block has no clock; each
// check is guarded so that unknown inputs at start do not trigger it.
module vsd_checker #(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input logic            req_valid,
    input logic [VA_W-1:0] vaddr,
    input logic            is_store,
    input logic [1:0]      mode_field,
    input logic            exl,
    input logic            erl,
    input logic            is_lookup,
    input logic            is_direct,
    input logic            is_fault,
    input logic [PA_W-1:0] phys_addr,
    input logic            phys_cached,
    input logic [1:0]      fault_code,
    input logic            ext_addr
);

    logic kernel_req;
    logic high_phys;
    logic low_seg;

    // Request-side predicates used by several checks.
    always_comb begin
        kernel_req = exl || erl || (mode_field == 2'b00);
        high_phys  = (vaddr[VA_W-1:VA_W-2] == 2'b10);
        low_seg    = (vaddr[VA_W-1:31] == '0);
    end

    // Route and output consistency checks.
    always_comb begin
        if (req_valid === 1'b1) begin
            AST_SINGLE_ROUTE: assert ($countones({is_lookup, is_direct, is_fault}) == 1)
                else $error("route not one-hot"); // R3
            AST_PHYS_WINDOW: assert (!high_phys || (is_direct && phys_addr == vaddr[PA_W-1:0] && phys_cached))
                else $error("physical window misrouted"); // R5
            AST_LOW_MAPPED: assert (!(low_seg && !erl) || is_lookup)
                else $error("low segment not mapped"); // R6
            AST_KERNEL_NO_FAULT: assert (!kernel_req || !is_fault)
                else $error("kernel access faulted"); // R10
            AST_FAULT_CODE: assert (is_fault ? (fault_code == (is_store ? 2'b10 : 2'b01)) : (fault_code == 2'b00))
                else $error("fault code wrong"); // R11
            AST_NONDIRECT_ZERO: assert (is_direct || (phys_addr == '0 && !phys_cached))
                else $error("direct outputs leak"); // R12
        end else if (req_valid === 1'b0) begin
            AST_IDLE_SILENT: assert (!is_lookup && !is_direct && !is_fault && phys_addr == '0
                                     && !phys_cached && fault_code == 2'b00 && !ext_addr)
                else $error("idle outputs not zero"); // R4
        end
    end

endmodule

bind va_segment_decoder vsd_checker #(
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_vsd_chk (
    .req_valid   (req_valid),
    .vaddr       (vaddr),
    .is_store    (is_store),
    .mode_field  (mode_field),
    .exl         (exl),
    .erl         (erl),
    .is_lookup   (is_lookup),
    .is_direct   (is_direct),
    .is_fault    (is_fault),
    .phys_addr   (phys_addr),
    .phys_cached (phys_cached),
    .fault_code  (fault_code),
    .ext_addr    (ext_addr)
);

// File: tb/va_segment_decoder_test.sv
`timescale 1ns/1ps
// Sweep bench for the segment decoder: all control combinations over a
// set of boundary addresses, then pseudo-random addresses.
module va_segment_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] vaddr = '0;
    logic        is_store = 1'b0;
    logic [1:0]  mode_field = 2'b00;
    logic        exl = 1'b0;
    logic        erl = 1'b0;
    logic        ux_en = 1'b0;
    logic        sx_en = 1'b0;
    logic        kx_en = 1'b0;
    logic        is_lookup;
    logic        is_direct;
    logic        is_fault;
    logic [43:0] phys_addr;
    logic        phys_cached;
    logic [1:0]  fault_code;
    logic        ext_addr;

    int unsigned checks = 0;
    int unsigned errors = 0;

    always #2.5 clk = ~clk;

    va_segment_decoder uut (
        .req_valid   (req_valid),
        .vaddr       (vaddr),
        .is_store    (is_store),
        .mode_field  (mode_field),
        .exl         (exl),
        .erl         (erl),
        .ux_en       (ux_en),
        .sx_en       (sx_en),
        .kx_en       (kx_en),
        .is_lookup   (is_lookup),
        .is_direct   (is_direct),
        .is_fault    (is_fault),
        .phys_addr   (phys_addr),
        .phys_cached (phys_cached),
        .fault_code  (fault_code),
        .ext_addr    (ext_addr)
    );

    // Boundary addresses exercised in every control combination.
    function automatic logic [63:0] pick_addr(input int k);
        case (k)
            0:  return 64'h0000_0000_0000_0000;
            1:  return 64'h0000_0000_0000_1234;
            2:  return 64'h0000_0000_7FFF_FFFF;
            3:  return 64'h0000_0000_8000_0000;
            4:  return 64'h0000_0000_9FFF_FFFF;
            5:  return 64'h0000_0000_A000_0000;
            6:  return 64'h0000_0000_BFFF_FFFF;
            7:  return 64'h0000_0000_C000_0000;
            8:  return 64'h0000_0000_FFFF_FFFF;
            9:  return 64'h0000_0001_0000_0000;
            10: return 64'hFFFF_FFFF_8000_0000;
            11: return 64'hFFFF_FFFF_BFFF_FFFF;
            12: return 64'hFFFF_FFFF_C000_0000;
            13: return 64'hFFFF_FFFF_7FFF_FFFF;
            14: return 64'h8000_0000_0000_0000;
            15: return 64'hBFFF_FFFF_FFFF_FFFF;
            16: return 64'h9000_0000_1F60_0050;
            17: return 64'h4000_0000_0000_1000;
            18: return 64'hC000_0000_0000_0000;
            19: return 64'h7FFF_FFFF_FFFF_FFFF;
            20: return 64'h0000_0000_8001_2345;
            21: return 64'hFFFF_FFFF_9FFF_FFFF;
            22: return 64'hFFFF_FFFF_A000_0000;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Reference classification computed from the requirements.
    function automatic void model(
        input  logic [1:0]  md,
        input  logic        e_x, e_r, u, s, kx, st,
        input  logic [63:0] va,
        output logic        x_tlb, x_dir, x_flt,
        output logic [43:0] x_pa,
        output logic        x_c,
        output logic [1:0]  x_fc,
        output logic        x_ext,
        output string       tag
    );
        logic        kern;
        logic        sup;
        logic [63:0] v;
        logic        sext;
        kern = e_x || e_r || (md == 2'd0);
        sup  = !kern && (md == 2'd1);
        x_ext = kern ? kx : (sup ? s : u);
        x_tlb = 0; x_dir = 0; x_flt = 0; x_pa = '0; x_c = 0; x_fc = 2'd0;
        v = va; sext = 0;
        if (va >= 64'h8000_0000 && va < 64'h1_0000_0000) begin
            v = va + 64'hFFFF_FFFF_0000_0000;
            sext = 1;
        end
        if (va >= 64'h8000_0000_0000_0000 && va < 64'hC000_0000_0000_0000) begin
            x_dir = 1; x_pa = va[43:0]; x_c = 1; tag = "R5";
        end else if (va <= 64'h7FFF_FFFF) begin
            if (e_r) begin
                x_dir = 1; x_pa = va[43:0]; tag = "R7";
            end else begin
                x_tlb = 1; tag = "R6";
            end
        end else if (kern) begin
            if (v >= 64'hFFFF_FFFF_8000_0000 && v <= 64'hFFFF_FFFF_BFFF_FFFF) begin
                x_dir = 1;
                x_pa  = 44'(v - 64'hFFFF_FFFF_8000_0000) % 44'h2000_0000;
                x_c   = (v < 64'hFFFF_FFFF_A000_0000);
                tag = "R9";
            end else begin
                x_tlb = 1; tag = "R10";
            end
        end else begin
            x_flt = 1; x_fc = st ? 2'd2 : 2'd1; tag = "R11";
        end
        if (sext) tag = {tag, " R8"};
        if ((e_x || e_r) && md != 2'd0) tag = {tag, " R1"};
        if (!e_x && !e_r && md == 2'd3) tag = {tag, " R1"};
    endfunction

    // Apply one request and compare every output against the model.
    task automatic run_vec(input logic [63:0] va, input logic [1:0] md,
                           input logic e_x, e_r, u, s, kx, st);
        logic        x_tlb, x_dir, x_flt, x_c, x_ext;
        logic [43:0] x_pa;
        logic [1:0]  x_fc;
        string       tag;
        model(md, e_x, e_r, u, s, kx, st, va, x_tlb, x_dir, x_flt, x_pa, x_c, x_fc, x_ext, tag);
        @(negedge clk);
        req_valid = 1; vaddr = va; mode_field = md; exl = e_x; erl = e_r;
        ux_en = u; sx_en = s; kx_en = kx; is_store = st;
        #1;
        checks++;
        if ({is_lookup, is_direct, is_fault, phys_addr, phys_cached, fault_code}
            !== {x_tlb, x_dir, x_flt, x_pa, x_c, x_fc}) begin
            errors++;
            $display("FAIL %s va=%h md=%0d exl=%0d erl=%0d st=%0d: got t/d/f=%b%b%b pa=%h c=%b fc=%b exp t/d/f=%b%b%b pa=%h c=%b fc=%b",
                     tag, va, md, e_x, e_r, st, is_lookup, is_direct, is_fault, phys_addr,
                     phys_cached, fault_code, x_tlb, x_dir, x_flt, x_pa, x_c, x_fc);
        end
        checks++;
        if (ext_addr !== x_ext) begin
            errors++;
            $display("FAIL R2 md=%0d exl=%0d erl=%0d ux/sx/kx=%b%b%b: got ext=%b exp %b",
                     md, e_x, e_r, u, s, kx, ext_addr, x_ext);
        end
        checks++;
        if ((32'(is_lookup) + 32'(is_direct) + 32'(is_fault)) != 1) begin
            errors++;
            $display("FAIL R3 va=%h: got t/d/f=%b%b%b exp exactly one set",
                     va, is_lookup, is_direct, is_fault);
        end
        checks++;
        if (!is_direct && (phys_addr !== '0 || phys_cached !== 1'b0)) begin
            errors++;
            $display("FAIL R12 va=%h: got pa=%h c=%b exp pa=0 c=0", va, phys_addr, phys_cached);
        end
    endtask

    // Drop the request and check that every output is zero.
    task automatic idle_check(input logic [63:0] va, input logic e_r, input logic st);
        @(negedge clk);
        req_valid = 0; vaddr = va; erl = e_r; is_store = st;
        ux_en = 1; sx_en = 1; kx_en = 1;
        #1;
        checks++;
        if ({is_lookup, is_direct, is_fault, phys_addr, phys_cached, fault_code, ext_addr} !== '0) begin
            errors++;
            $display("FAIL R4 va=%h: got t/d/f=%b%b%b pa=%h c=%b fc=%b ext=%b exp all zero",
                     va, is_lookup, is_direct, is_fault, phys_addr, phys_cached, fault_code, ext_addr);
        end
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [63:0] lf;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: no request, all outputs quiet (R4).
        idle_check(64'h0, 1'b0, 1'b0);
        idle_check(64'hFFFF_FFFF_8000_0000, 1'b1, 1'b1);
        // Exhaustive control sweep over boundary addresses.
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 24; k++) begin
                logic [7:0] cb;
                cb = 8'(c);
                run_vec(pick_addr(k), cb[1:0], cb[2], cb[3], cb[4], cb[5], cb[6], cb[7]);
            end
        end
        // Pseudo-random addresses shaped toward each region.
        lf = 64'h1234_5678_9ABC_DEF1;
        for (int n = 0; n < 2000; n++) begin
            logic [63:0] va;
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 7);
            lf = lf ^ (lf << 17);
            case (lf[2:0])
                3'd0: va = {32'h0, lf[63:32]};
                3'd1: va = {32'hFFFF_FFFF, lf[63:32]};
                3'd2: va = {2'b10, lf[63:2]};
                3'd3: va = {33'h0, lf[62:32]};
                default: va = lf;
            endcase
            run_vec(va, lf[4:3], lf[5], lf[6], lf[7], lf[8], lf[9], lf[10]);
            if (lf[15:11] == 5'd0) idle_check(va, lf[6], lf[10]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule